// File: doc/BRIEF.md
# LED Output Guard with Staggered Turn-On

This block sits between the per-channel PWM enables of a sixteen-channel constant-current LED driver and its output switches. Its first job is to spread switching edges over time. Channels are sorted into four groups by channel index modulo four. Each group sees the PWM enables later than the group before it by a fixed number of system-clock ticks. At a 25 MHz system clock one tick is 40 ns, so the groups lag by 0, 40, 80 and 120 ns. This lowers the peak inrush current drawn from the LED supply.

It also applies two protective blanks that force every output off without delay.

- **Grey-scale clock watchdog.** It trips when no rising edge of the grey-scale clock has been seen for a programmable number of system-clock cycles, about one second by default. Once tripped, it releases only after the grey-scale clock is toggling again and a fresh serial-data strobe has arrived. At release it pulses a restart request to the PWM counters.
- **Thermal guard.** It takes over-temperature and under-temperature indications from an analog comparator and keeps a thermal flag. When shutdown is enabled, it blanks the outputs with hysteresis.

Throughout both blanks the enable pipeline keeps running, so the data path stays live.

Top module: `opg_out_guard`

## Requirements
- R1: While reset is held, all drive outputs, the thermal flag, the clock-loss indication and the restart pulse are 0.
- R2: With no blank active, each drive output equals its PWM enable once the pipeline has settled.
- R3: A rising PWM enable on channel c appears at its drive output 1 + (c mod 4)·STEP cycles after the capturing clock edge. With STEP = 1, the drive pattern is 0x1111, 0x3333, 0x7777 and 0xFFFF in the four cycles after all enables rise together.
- R4: Falling enables are delayed in the same way as rising ones. With STEP = 1 the drive pattern is 0xEEEE, 0xCCCC, 0x8888 and 0x0000.
- R5: With the watchdog enabled (disable input 0), the clock-loss output goes to 1 after TIMEOUT cycles without a grey-scale clock rising edge. While it is 1, all drive outputs are 0.
- R6: With the watchdog disable input at 1, the watchdog never trips and the outputs keep following the enables.
- R7: After a trip, neither a returning grey-scale clock alone nor a data strobe alone releases the blank. Release needs both, in either order.
- R8: On release, the restart output is 1 for exactly one cycle, and the drive outputs resume following the enables.
- R9: The thermal flag becomes 1 on an over-temperature indication and returns to 0 on an under-temperature indication, whether or not shutdown is enabled. With neither indication present it holds its value.
- R10: With shutdown enabled, an over-temperature indication forces all drive outputs to 0. They stay 0 while neither indication is present and are released on an under-temperature indication.
- R11: With shutdown disabled, an over-temperature indication leaves the drive outputs unchanged.
- R12: The enable pipeline keeps running during a thermal blank. In the first cycle after release, the outputs show the enables applied during the blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one tick = one stagger step) |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_en_i | input | 16 | Per-channel PWM on request |
| pwclk_i | input | 1 | Grey-scale clock, asynchronous to clk |
| data_strobe_i | input | 1 | One-cycle pulse: new serial data shifted in |
| wd_disable_i | input | 1 | 1 disables the clock-loss watchdog |
| tsd_enable_i | input | 1 | 1 enables thermal shutdown |
| temp_over_i | input | 1 | Over-temperature comparator output, asynchronous |
| temp_under_i | input | 1 | Under-temperature comparator output, asynchronous |
| drive_o | output | 16 | Gated, staggered output switch enables |
| thermal_flag_o | output | 1 | Thermal warning flag |
| clk_loss_o | output | 1 | Watchdog tripped, outputs blanked |
| pwm_restart_o | output | 1 | One-cycle request to reset PWM counters |

## Verification
The bench walks each group's edge cycle by cycle in both directions. A tap taken from the wrong stage, or a stagger applied only to rising edges, shows up as a wrong mask such as 0x3333 in place of 0x1111.

It trips the watchdog twice and supplies the two release conditions in opposite orders. A design that releases on either condition alone would show drive outputs during the wait. The restart output is counted across the release window, so a level in place of a pulse is reported.

Thermal tests cover the band between the two thresholds, where a design without hysteresis would turn on early. They also check the first cycle after release, where a frozen pipeline would still show stale enables.

// File: rtl/opg_pkg.sv
// Package: shared constants and helpers for the output guard.
// Assumes channels are grouped by index modulo OPG_GROUPS.
package opg_pkg;
    localparam int unsigned OPG_GROUPS = 4;

    // Group a channel belongs to; its stagger rank.
    function automatic int unsigned opg_group_of(input int unsigned ch);
        return ch % OPG_GROUPS;
    endfunction

    typedef enum logic {
        WD_RUN  = 1'b0,
        WD_TRIP = 1'b1
    } wd_state_t;

    typedef enum logic {
        TH_NORMAL = 1'b0,
        TH_BLANK  = 1'b1
    } th_state_t;
endpackage

// File: rtl/opg_stagger.sv
// Stagger delay line: delays every channel enable by one register plus
// (group * STEP) further system-clock cycles. Both edges are delayed alike.
// Assumes STEP is small (a few ticks); storage is (3*STEP+1) x N flops.
module opg_stagger
    import opg_pkg::*;
#(
    parameter int unsigned N    = 16,
    parameter int unsigned STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_in,
    output logic [N-1:0] en_out
);
    localparam int unsigned DEPTH = (OPG_GROUPS - 1) * STEP + 1;

    logic [N-1:0] line_q [DEPTH];

    // Shift the whole enable vector one stage per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
        end else begin
            line_q[0] <= en_in;
            for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
        end
    end

    // Pick each channel's tap according to its group.
    for (genvar ch = 0; ch < N; ch++) begin : g_tap
        localparam int unsigned TAP = opg_group_of(ch) * STEP;
        assign en_out[ch] = line_q[TAP][ch];
    end

    // R3: group 0 of channel 0 follows the input one cycle later.
    a_r3_group0_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> en_out[0] == $past(en_in[0]));
endmodule

// File: rtl/opg_clk_watch.sv
// Grey-scale clock watchdog: synchronises the clock, detects rising edges
// and counts system cycles since the last one. After TIMEOUT idle cycles it
// trips; it releases only when the clock is back AND a data strobe arrived
// after the trip, and then pulses restart. Assumes pwclk is much slower
// than clk (at least two clk cycles per level).
module opg_clk_watch
    import opg_pkg::*;
#(
    parameter int unsigned TIMEOUT = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwclk,
    input  logic data_strobe,
    input  logic wd_disable,
    output logic tripped,
    output logic restart
);
    localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic          pw_meta, pw_sync, pw_prev;
    logic          pw_rise;
    logic [CW-1:0] idle_cnt;
    wd_state_t     state_q;
    logic          clk_back_q, data_seen_q;
    logic          release_now;

    // Two-flop synchroniser plus history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_meta <= 1'b0;
            pw_sync <= 1'b0;
            pw_prev <= 1'b0;
        end else begin
            pw_meta <= pwclk;
            pw_sync <= pw_meta;
            pw_prev <= pw_sync;
        end
    end

    assign pw_rise = pw_sync & ~pw_prev;

    // Idle counter: cleared on each edge, held at zero while off or tripped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (wd_disable || pw_rise || state_q == WD_TRIP) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign release_now = (state_q == WD_TRIP)
                       && (clk_back_q || pw_rise)
                       && (data_seen_q || data_strobe);

    // Trip / release state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
        end else if (wd_disable) begin
            state_q <= WD_RUN;
        end else if (state_q == WD_RUN && idle_cnt == LAST && !pw_rise) begin
            state_q <= WD_TRIP;
        end else if (release_now) begin
            state_q <= WD_RUN;
        end
    end

    // Sticky release conditions, collected only while tripped.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != WD_TRIP || release_now) begin
            clk_back_q  <= 1'b0;
            data_seen_q <= 1'b0;
        end else begin
            if (pw_rise)     clk_back_q  <= 1'b1;
            if (data_strobe) data_seen_q <= 1'b1;
        end
    end

    // One-cycle restart request on release.
    always_ff @(posedge clk) begin
        if (!rst_n) restart <= 1'b0;
        else        restart <= release_now && !wd_disable;
    end

    assign tripped = (state_q == WD_TRIP);

    // R6: a disabled watchdog is never tripped.
    a_r6_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable |=> !tripped);
    // R8: restart never lasts two cycles.
    a_r8_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);
    // R8: restart only accompanies the end of a trip.
    a_r8_restart_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !tripped && $past(tripped));
    // R5: the idle counter never passes its limit.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST);
endmodule

// File: rtl/opg_thermal.sv
// Thermal guard: synchronises the two comparator indications, keeps the
// warning flag and, when enabled, a blanking state with hysteresis.
// Over-temperature wins if both indications are seen together.
module opg_thermal
    import opg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic temp_over,
    input  logic temp_under,
    input  logic tsd_enable,
    output logic flag,
    output logic blank
);
    logic      over_m, over_s, under_m, under_s;
    th_state_t state_q;

    // Synchronise the asynchronous comparator outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_m  <= 1'b0;
            over_s  <= 1'b0;
            under_m <= 1'b0;
            under_s <= 1'b0;
        end else begin
            over_m  <= temp_over;
            over_s  <= over_m;
            under_m <= temp_under;
            under_s <= under_m;
        end
    end

    // Warning flag: set hot, cleared cool, independent of shutdown enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (over_s)  flag <= 1'b1;
        else if (under_s) flag <= 1'b0;
    end

    // Shutdown state with hysteresis between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)                      state_q <= TH_NORMAL;
        else if (!tsd_enable)            state_q <= TH_NORMAL;
        else if (over_s)                 state_q <= TH_BLANK;
        else if (under_s)                state_q <= TH_NORMAL;
    end

    assign blank = (state_q == TH_BLANK);

    // R10: blanking requires shutdown to have been enabled.
    a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !tsd_enable |=> !blank);
    // R9: a cool indication without a hot one clears the flag.
    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (under_s && !over_s) |=> !flag);
    // R10: hysteresis, the blank holds with neither indication.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && tsd_enable && !over_s && !under_s) |=> blank);
endmodule

// File: rtl/opg_out_guard.sv
// Output guard top: staggers the PWM enables in four groups and blanks all
// outputs immediately on grey-scale clock loss or thermal shutdown.
// Assumes clk is the stagger time base (25 MHz gives 40 ns per step).
module opg_out_guard
    import opg_pkg::*;
#(
    parameter int unsigned N_CH        = 16,
    parameter int unsigned STEP_TICKS  = 1,
    parameter int unsigned TIMEOUT_CYC = 25_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pwm_en_i,
    input  logic            pwclk_i,
    input  logic            data_strobe_i,
    input  logic            wd_disable_i,
    input  logic            tsd_enable_i,
    input  logic            temp_over_i,
    input  logic            temp_under_i,
    output logic [N_CH-1:0] drive_o,
    output logic            thermal_flag_o,
    output logic            clk_loss_o,
    output logic            pwm_restart_o
);
    logic [N_CH-1:0] staggered;
    logic            th_blank;

    opg_stagger #(.N(N_CH), .STEP(STEP_TICKS)) u_stagger (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (pwm_en_i),
        .en_out (staggered)
    );

    opg_clk_watch #(.TIMEOUT(TIMEOUT_CYC)) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwclk       (pwclk_i),
        .data_strobe (data_strobe_i),
        .wd_disable  (wd_disable_i),
        .tripped     (clk_loss_o),
        .restart     (pwm_restart_o)
    );

    opg_thermal u_thermal (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_over  (temp_over_i),
        .temp_under (temp_under_i),
        .tsd_enable (tsd_enable_i),
        .flag       (thermal_flag_o),
        .blank      (th_blank)
    );

    // Final gating: either blank cuts every output at once.
    always_comb begin
        drive_o = (clk_loss_o || th_blank) ? '0 : staggered;
    end

    // R5: clock loss leaves no output on.
    a_r5_loss_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        clk_loss_o |-> drive_o == '0);
    // R10: a thermal blank leaves no output on.
    a_r10_blank_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        th_blank |-> drive_o == '0);
    // R2: an output can only be on if its enable was on recently (channel 0).
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && drive_o[0] |-> $past(pwm_en_i[0]));
endmodule

// File: tb/test_opg_out_guard.sv
module test_opg_out_guard;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pwm_en = '0;
    logic          pwclk = 1'b0;
    logic          strobe = 1'b0;
    logic          wd_off = 1'b0;
    logic          tsd_en = 1'b0;
    logic          t_over = 1'b0;
    logic          t_under = 1'b0;
    logic [N-1:0]  drive;
    logic          tflag, loss, restart;
    logic          pw_run = 1'b0;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    opg_out_guard #(.N_CH(N), .STEP_TICKS(1), .TIMEOUT_CYC(40)) i_opg_out_guard (
        .clk(clk), .rst_n(rst_n), .pwm_en_i(pwm_en), .pwclk_i(pwclk),
        .data_strobe_i(strobe), .wd_disable_i(wd_off), .tsd_enable_i(tsd_en),
        .temp_over_i(t_over), .temp_under_i(t_under), .drive_o(drive),
        .thermal_flag_o(tflag), .clk_loss_o(loss), .pwm_restart_o(restart)
    );

    // Grey-scale clock source: toggles every 3 system cycles while running.
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1;
            if (pw_run) pwclk = ~pwclk;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    localparam logic [N-1:0] VEC [6] = '{16'h0000, 16'hFFFF, 16'hA5A5,
                                        16'h0001, 16'h8000, 16'h3C96};

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int rs;
        // R1: reset state
        nwait(3);
        chk("R1 drive", 32'(drive), 32'h0);
        chk("R1 flag", 32'(tflag), 32'h0);
        chk("R1 loss", 32'(loss), 32'h0);
        chk("R1 restart", 32'(restart), 32'h0);
        rst_n = 1'b1;
        pw_run = 1'b1;

        // R2: vector table, steady state follows enables
        for (int i = 0; i < 6; i++) begin
            pwm_en = VEC[i];
            nwait(6);
            chk("R2 steady", 32'(drive), 32'(VEC[i]));
        end

        // R3: staggered rise
        pwm_en = 16'h0000; nwait(6);
        pwm_en = 16'hFFFF;
        nwait(1); chk("R3 step1", 32'(drive), 32'h1111);
        nwait(1); chk("R3 step2", 32'(drive), 32'h3333);
        nwait(1); chk("R3 step3", 32'(drive), 32'h7777);
        nwait(1); chk("R3 step4", 32'(drive), 32'hFFFF);
        // R4: staggered fall
        pwm_en = 16'h0000;
        nwait(1); chk("R4 step1", 32'(drive), 32'hEEEE);
        nwait(1); chk("R4 step2", 32'(drive), 32'hCCCC);
        nwait(1); chk("R4 step3", 32'(drive), 32'h8888);
        nwait(1); chk("R4 step4", 32'(drive), 32'h0000);

        // R5: trip on clock loss
        pwm_en = 16'hFFFF; nwait(6);
        chk("R5 before loss", 32'(loss), 32'h0);
        pw_run = 1'b0;
        nwait(60);
        chk("R5 tripped", 32'(loss), 32'h1);
        chk("R5 blanked", 32'(drive), 32'h0);
        // R7: clock back alone does not release
        pw_run = 1'b1;
        nwait(20);
        chk("R7 clock only", 32'(loss), 32'h1);
        chk("R7 clock only drive", 32'(drive), 32'h0);
        // R8: strobe releases with a single restart pulse
        rs = 0;
        strobe = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            strobe = 1'b0;
            if (restart) rs++;
        end
        chk("R8 restart count", 32'(rs), 32'd1);
        chk("R8 released", 32'(loss), 32'h0);
        chk("R8 drive resumes", 32'(drive), 32'hFFFF);

        // R7: data alone does not release, clock then completes it
        pw_run = 1'b0;
        nwait(60);
        chk("R7 second trip", 32'(loss), 32'h1);
        pulse_strobe();
        nwait(10);
        chk("R7 data only", 32'(loss), 32'h1);
        chk("R7 data only drive", 32'(drive), 32'h0);
        pw_run = 1'b1;
        nwait(20);
        chk("R7 both released", 32'(loss), 32'h0);
        chk("R7 drive back", 32'(drive), 32'hFFFF);

        // R6: watchdog disabled never trips
        wd_off = 1'b1;
        pw_run = 1'b0;
        nwait(80);
        chk("R6 no trip", 32'(loss), 32'h0);
        chk("R6 drive", 32'(drive), 32'hFFFF);
        pw_run = 1'b1;
        nwait(10);
        wd_off = 1'b0;
        nwait(5);

        // R9 and R11: flag with shutdown disabled
        t_over = 1'b1; nwait(5);
        chk("R9 flag set", 32'(tflag), 32'h1);
        chk("R11 drive unchanged", 32'(drive), 32'hFFFF);
        t_over = 1'b0; nwait(5);
        chk("R9 flag holds", 32'(tflag), 32'h1);
        t_under = 1'b1; nwait(5);
        chk("R9 flag cleared", 32'(tflag), 32'h0);
        t_under = 1'b0; nwait(3);

        // R10: shutdown with hysteresis
        tsd_en = 1'b1;
        t_over = 1'b1; nwait(5);
        chk("R10 shut", 32'(drive), 32'h0);
        chk("R10 flag", 32'(tflag), 32'h1);
        t_over = 1'b0; nwait(6);
        chk("R10 hysteresis", 32'(drive), 32'h0);
        // R12: pipeline runs during blank
        pwm_en = 16'h0F0F; nwait(6);
        t_under = 1'b1;
        nwait(2);
        chk("R10 still off", 32'(drive), 32'h0);
        nwait(1);
        chk("R12 first cycle", 32'(drive), 32'h0F0F);
        t_under = 1'b0;
        nwait(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule